// File: doc/BRIEF.md
# Rectangular Memory Block Transfer Engine

This engine moves a rectangle of 16-bit words from one area of memory to another. For every destination word it forms a pattern word from a shifted source word and a halftone word, mixes that pattern with the current destination word through any of the sixteen two-input boolean functions, and blends the result into the destination under an edge mask. The edge masks allow rectangles whose left and right edges are not aligned to words.

Software loads the addresses, increments, counts, masks, halftone table and operation fields through a small register port. It then writes the start bit and waits for `busy` to fall. The engine reaches memory through one request/acknowledge port. It holds each request with a steady address until the acknowledge arrives. While a transfer runs, `hog_req` can ask the system to leave the bus to the engine.

Top module: `blit_engine`

## Requirements
- R1: After reset `busy`, `hog_req` and `mem_req` are 0 and every register reads back 0.
- R2: Writing 1 to bit 7 of the control register (address 28) starts a transfer. `busy`, and bit 7 on readback, stay 1 until the last word is written. Register writes made while busy are ignored.
- R3: `hog_req` equals the hog bit (control bit 6) while busy and is 0 otherwise.
- R4: A words-per-line count (address 22) or a line count (address 23) of 0 stands for 65536. The line count counts down live and reads 0 after a full transfer.
- R5: The pattern select (address 27, bits 5:4) chooses the pattern word: 0 gives all ones, 1 the halftone word, 2 the shifted source, and 3 the source AND the halftone word.
- R6: The function code (address 27, bits 3:0) gives result bit = code[{~P,~D}]. Code bit 0 covers P=1,D=1; bit 1 covers P=1,D=0; bit 2 covers P=0,D=1; bit 3 covers P=0,D=0.
- R7: The halftone word is entry `line` (control bits 3:0) of the 16-entry table at addresses 0..15. When smudge (control bit 5) is set, the entry is instead the low 4 bits of the shifted source.
- R8: Each source read shifts the word into a 32-bit buffer, {older, newer}. The source word used is bits 15:0 of the buffer shifted right by the skew field (address 29, bits 3:0). The buffer is cleared at start.
- R9: With the extra-read bit (address 29, bit 7) set, each line starts with one additional source read. With the no-final-read bit (address 29, bit 6) set, the last word of a line reads no source.
- R10: The first word of a line uses mask 1 (address 24), middle words use mask 2 (25) and the last word uses mask 3 (26). A one-word line uses mask 1. The word written is (result AND mask) OR (old AND NOT mask).
- R11: Addresses are even. The destination address adds its X increment after each word, or its Y increment after the last word of a line. The source address adds X after each read, or Y on the last word's read. If the last word has no read, Y is added at the end of the line.
- R12: At the end of each line the line field steps by -1 when the destination Y increment is negative and by +1 otherwise, wrapping in 4 bits.
- R13: The destination read is skipped when the function code ignores D and the mask is all ones. No source is read when the pattern select is below 2 and smudge is clear.
- R14: `mem_req` is high only while busy. Once raised, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, always even |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Transfer in progress |
| hog_req | output | 1 | Request for exclusive bus use |

## Verification
The assertions assume that the memory side asserts `mem_ack` only while `mem_req` is high. They also assume that the register port never writes the start bit and another register in the same cycle. The bench's memory model acknowledges either one cycle after a request or in the same cycle, and never without a request. All register programming is issued while the engine is idle. The one exception is a deliberate write during a transfer, which tests that such writes are ignored.

// File: rtl/blit_engine.sv
module blit_engine #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          busy,
  output logic          hog_req
);
  localparam logic [4:0] A_SA = 5'd16, A_SXI = 5'd17, A_SYI = 5'd18, A_DA = 5'd19,
                         A_DXI = 5'd20, A_DYI = 5'd21, A_XC = 5'd22, A_YC = 5'd23,
                         A_M1 = 5'd24, A_M2 = 5'd25, A_M3 = 5'd26, A_OP = 5'd27,
                         A_CTL = 5'd28, A_SH = 5'd29;
  localparam int PADW = 32 - AW;

  typedef enum logic [2:0] {S_IDLE, S_GO, S_FX, S_SRC, S_DRD, S_WR} st_t;

  st_t st;
  logic [15:0] ht [16];
  logic [AW-1:0] sa, da;
  logic [15:0] sxi, syi, dxi, dyi, xcnt, ycnt, xrem, m1, m2, m3;
  logic [1:0] hop;
  logic [3:0] lop, lnum, skew;
  logic hog, smudge, fxsr, nfsr, first, srd;
  logic [31:0] sbuf;
  logic [15:0] dreg, pat, res;

  wire last   = (xrem == 16'd1);
  wire d_used = (lop[3] ^ lop[2]) | (lop[1] ^ lop[0]);
  wire s_used = hop[1] | smudge;

  function automatic logic [AW-1:0] stepv(input logic [15:0] v);
    return {{(AW-16){v[15]}}, v[15:1], 1'b0};
  endfunction

  function automatic logic [15:0] pick_mask(input logic f, input logic l);
    return f ? m1 : (l ? m3 : m2);
  endfunction

  function automatic st_t after_src(input logic f, input logic l);
    return (d_used || pick_mask(f, l) != 16'hffff) ? S_DRD : S_WR;
  endfunction

  function automatic st_t after_fx(input logic f, input logic l);
    return (s_used && !(l && nfsr)) ? S_SRC : after_src(f, l);
  endfunction

  function automatic st_t word_entry(input logic f, input logic l);
    return (f && fxsr && s_used) ? S_FX : after_fx(f, l);
  endfunction

  wire [31:0] shv = sbuf >> skew;
  wire [15:0] sw  = shv[15:0];
  wire [15:0] htw = ht[smudge ? sw[3:0] : lnum];
  wire [15:0] cm  = pick_mask(first, last);

  always_comb begin
    case (hop)
      2'd0: pat = 16'hffff;
      2'd1: pat = htw;
      2'd2: pat = sw;
      default: pat = sw & htw;
    endcase
    for (int i = 0; i < 16; i++) res[i] = lop[{~pat[i], ~dreg[i]}];
  end

  assign busy      = (st != S_IDLE);
  assign hog_req   = busy & hog;
  assign mem_req   = busy && (st != S_GO);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_FX || st == S_SRC) ? sa : da;
  assign mem_wdata = (res & cm) | (dreg & ~cm);

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[4]) reg_rdata = {16'd0, ht[reg_addr[3:0]]};
    else case (reg_addr)
      A_SA:  reg_rdata = {{PADW{1'b0}}, sa};
      A_SXI: reg_rdata = {16'd0, sxi};
      A_SYI: reg_rdata = {16'd0, syi};
      A_DA:  reg_rdata = {{PADW{1'b0}}, da};
      A_DXI: reg_rdata = {16'd0, dxi};
      A_DYI: reg_rdata = {16'd0, dyi};
      A_XC:  reg_rdata = {16'd0, xcnt};
      A_YC:  reg_rdata = {16'd0, ycnt};
      A_M1:  reg_rdata = {16'd0, m1};
      A_M2:  reg_rdata = {16'd0, m2};
      A_M3:  reg_rdata = {16'd0, m3};
      A_OP:  reg_rdata = {26'd0, hop, lop};
      A_CTL: reg_rdata = {24'd0, busy, hog, smudge, 1'b0, lnum};
      A_SH:  reg_rdata = {24'd0, fxsr, nfsr, 2'b00, skew};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < 16; i++) ht[i] <= '0;
      sa <= '0; da <= '0;
      sxi <= '0; syi <= '0; dxi <= '0; dyi <= '0;
      xcnt <= '0; ycnt <= '0; xrem <= '0;
      m1 <= '0; m2 <= '0; m3 <= '0;
      hop <= '0; lop <= '0; lnum <= '0; skew <= '0;
      hog <= 1'b0; smudge <= 1'b0; fxsr <= 1'b0; nfsr <= 1'b0;
      first <= 1'b0; srd <= 1'b0; sbuf <= '0; dreg <= '0;
    end else begin
      case (st)
        S_IDLE: if (reg_we) begin
          if (!reg_addr[4]) ht[reg_addr[3:0]] <= reg_wdata[15:0];
          else case (reg_addr)
            A_SA:  sa   <= {reg_wdata[AW-1:1], 1'b0};
            A_SXI: sxi  <= {reg_wdata[15:1], 1'b0};
            A_SYI: syi  <= {reg_wdata[15:1], 1'b0};
            A_DA:  da   <= {reg_wdata[AW-1:1], 1'b0};
            A_DXI: dxi  <= {reg_wdata[15:1], 1'b0};
            A_DYI: dyi  <= {reg_wdata[15:1], 1'b0};
            A_XC:  xcnt <= reg_wdata[15:0];
            A_YC:  ycnt <= reg_wdata[15:0];
            A_M1:  m1   <= reg_wdata[15:0];
            A_M2:  m2   <= reg_wdata[15:0];
            A_M3:  m3   <= reg_wdata[15:0];
            A_OP:  begin hop <= reg_wdata[5:4]; lop <= reg_wdata[3:0]; end
            A_CTL: begin
              hog    <= reg_wdata[6];
              smudge <= reg_wdata[5];
              lnum   <= reg_wdata[3:0];
              if (reg_wdata[7]) begin
                st    <= S_GO;
                first <= 1'b1;
                xrem  <= xcnt;
                sbuf  <= '0;
                dreg  <= '0;
                srd   <= 1'b0;
              end
            end
            A_SH:  begin fxsr <= reg_wdata[7]; nfsr <= reg_wdata[6]; skew <= reg_wdata[3:0]; end
            default: ;
          endcase
        end
        S_GO: st <= word_entry(first, last);
        S_FX: if (mem_ack) begin
          sbuf <= {sbuf[15:0], mem_rdata};
          sa   <= sa + stepv(sxi);
          st   <= after_fx(first, last);
        end
        S_SRC: if (mem_ack) begin
          sbuf <= {sbuf[15:0], mem_rdata};
          sa   <= sa + stepv(last ? syi : sxi);
          srd  <= 1'b1;
          st   <= after_src(first, last);
        end
        S_DRD: if (mem_ack) begin
          dreg <= mem_rdata;
          st   <= S_WR;
        end
        S_WR: if (mem_ack) begin
          srd  <= 1'b0;
          dreg <= '0;
          if (last && !srd) sa <= sa + stepv(syi);
          if (last) begin
            da    <= da + stepv(dyi);
            lnum  <= dyi[15] ? lnum - 4'd1 : lnum + 4'd1;
            ycnt  <= ycnt - 16'd1;
            xrem  <= xcnt;
            first <= 1'b1;
            st    <= (ycnt == 16'd1) ? S_IDLE : word_entry(1'b1, xcnt == 16'd1);
          end else begin
            da    <= da + stepv(dxi);
            xrem  <= xrem - 16'd1;
            first <= 1'b0;
            st    <= word_entry(1'b0, xrem == 16'd2);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [4:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          busy,
  input logic          hog_req
);
  assert_req_in_busy_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_req_held_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_hog_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hog_req |-> busy);

  assert_even_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 5'd28 && reg_wdata[7]) |=> busy);

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !mem_req && !hog_req));
endmodule

bind blit_engine blit_engine_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .busy(busy), .hog_req(hog_req)
);

// File: tb/blit_engine_tb_top.sv
module blit_engine_tb_top;
  localparam int AW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack, busy, hog_req;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  blit_engine #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .hog_req(hog_req)
  );

  logic [15:0] mem [256];
  logic [15:0] em [256];
  int rd_cnt, wr_cnt, exp_rd, n_chk = 0, n_err = 0;
  bit fast = 0, ack_q = 0, finished = 0;

  function automatic int ix(int a);
    return (a >>> 1) & 255;
  endfunction

  assign mem_ack   = fast ? mem_req : ack_q;
  assign mem_rdata = mem[ix(int'(mem_addr))];

  always @(posedge clk) begin
    ack_q <= mem_req && !ack_q && !fast;
    if (mem_req && mem_ack) begin
      if (mem_we) begin mem[ix(int'(mem_addr))] <= mem_wdata; wr_cnt++; end
      else rd_cnt++;
    end
  end

  int c_sa, c_sxi, c_syi, c_da, c_dxi, c_dyi, c_w, c_h, f_s, f_d, f_ln;
  logic [15:0] c_m1, c_m2, c_m3;
  logic [15:0] c_ht [16];
  logic [1:0] c_hop;
  logic [3:0] c_lop, c_ln, c_skew;
  bit c_sm, c_fx, c_nf, c_hog;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_addr = 5'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic defaults();
    c_sa = 'h10; c_sxi = 2; c_syi = 2; c_da = 'h100; c_dxi = 2; c_dyi = 2;
    c_w = 4; c_h = 3; c_m1 = 16'hffff; c_m2 = 16'hffff; c_m3 = 16'hffff;
    c_hop = 2; c_lop = 4'h3; c_ln = 0; c_skew = 0;
    c_sm = 0; c_fx = 0; c_nf = 0; c_hog = 0;
    for (int i = 0; i < 16; i++) c_ht[i] = 16'(i * 16'h1111 ^ 16'h5a3c);
  endtask

  task automatic model();
    int s = c_sa, d = c_da, ln = c_ln, xl, yl;
    logic [31:0] bf = '0, shv;
    logic [15:0] sh, htw, p, m, dv, r;
    bit fst, lst, srd, su, du;
    xl = (c_w == 0) ? 65536 : c_w;
    yl = (c_h == 0) ? 65536 : c_h;
    su = c_hop[1] | c_sm;
    du = (c_lop[3] ^ c_lop[2]) | (c_lop[1] ^ c_lop[0]);
    exp_rd = 0;
    for (int y = 0; y < yl; y++) begin
      for (int x = 0; x < xl; x++) begin
        fst = (x == 0); lst = (x == xl - 1); srd = 0;
        if (fst && c_fx && su) begin bf = {bf[15:0], em[ix(s)]}; s += c_sxi; exp_rd++; end
        if (su && !(lst && c_nf)) begin
          bf = {bf[15:0], em[ix(s)]}; s += lst ? c_syi : c_sxi; exp_rd++; srd = 1;
        end
        shv = bf >> c_skew; sh = shv[15:0];
        htw = c_ht[c_sm ? int'(sh[3:0]) : (ln & 15)];
        case (c_hop)
          2'd0: p = 16'hffff;
          2'd1: p = htw;
          2'd2: p = sh;
          default: p = sh & htw;
        endcase
        m = fst ? c_m1 : (lst ? c_m3 : c_m2);
        dv = '0;
        if (du || m != 16'hffff) begin dv = em[ix(d)]; exp_rd++; end
        for (int b = 0; b < 16; b++) r[b] = c_lop[{~p[b], ~dv[b]}];
        em[ix(d)] = (r & m) | (dv & ~m);
        d += lst ? c_dyi : c_dxi;
        if (lst && !srd) s += c_syi;
      end
      ln = (c_dyi < 0) ? ln - 1 : ln + 1;
    end
    f_s = s & 'hffffff; f_d = d & 'hffffff; f_ln = ln & 15;
  endtask

  task automatic setup_and_start();
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + 7) ^ (i << 9));
    for (int i = 0; i < 256; i++) em[i] = mem[i];
    rd_cnt = 0; wr_cnt = 0;
    for (int i = 0; i < 16; i++) wr(i, int'(c_ht[i]));
    wr(16, c_sa); wr(17, c_sxi & 'hffff); wr(18, c_syi & 'hffff);
    wr(19, c_da); wr(20, c_dxi & 'hffff); wr(21, c_dyi & 'hffff);
    wr(22, c_w); wr(23, c_h);
    wr(24, int'(c_m1)); wr(25, int'(c_m2)); wr(26, int'(c_m3));
    wr(27, {26'd0, c_hop, c_lop});
    wr(29, {24'd0, c_fx, c_nf, 2'b00, c_skew});
    wr(28, {24'd0, 1'b1, c_hog, c_sm, 1'b0, c_ln});
  endtask

  task automatic finish_and_compare(string req);
    int v, bad;
    bad = -1;
    while (busy) @(negedge clk);
    model();
    for (int i = 0; i < 256; i++) if (mem[i] !== em[i] && bad < 0) bad = i;
    chk(bad < 0, req, "memory image", bad < 0 ? 0 : mem[bad], bad < 0 ? 0 : em[bad]);
    chk(rd_cnt == exp_rd, "R13", "read count", rd_cnt, exp_rd);
    rd(16, v); chk(v == f_s, "R11", "final source address", v, f_s);
    rd(19, v); chk(v == f_d, "R11", "final destination address", v, f_d);
    rd(28, v); chk((v & 15) == f_ln && v[7] == 0, "R12", "line field / busy", v, f_ln);
    rd(23, v); chk(v == 0, "R4", "line count readback", v, 0);
  endtask

  task automatic t_reset();
    int v;
    chk(!busy && !hog_req && !mem_req, "R1", "idle outputs", {busy, hog_req, mem_req}, 0);
    rd(16, v); chk(v == 0, "R1", "source address after reset", v, 0);
    rd(28, v); chk(v == 0, "R1", "control after reset", v, 0);
    rd(3, v);  chk(v == 0, "R1", "halftone entry after reset", v, 0);
  endtask

  task automatic t_copy();
    defaults();
    setup_and_start();
    @(negedge clk);
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    finish_and_compare("R5");
  endtask

  task automatic t_skew_fx();
    defaults();
    c_w = 3; c_h = 2; c_skew = 4; c_fx = 1; c_lop = 4'h6;
    c_m1 = 16'h0fff; c_m3 = 16'hf000; c_syi = 6; c_dyi = 10;
    setup_and_start();
    finish_and_compare("R8 R10 R6");
  endtask

  task automatic t_nfsr();
    defaults();
    c_w = 3; c_h = 2; c_skew = 12; c_fx = 1; c_nf = 1; c_lop = 4'hb;
    c_m2 = 16'h3c3c;
    setup_and_start();
    finish_and_compare("R9");
  endtask

  task automatic t_halftone();
    defaults();
    c_w = 1; c_h = 4; c_hop = 1; c_ln = 14; c_lop = 4'h3;
    c_m1 = 16'h00ff; c_m3 = 16'hff00; c_dyi = 6;
    setup_and_start();
    finish_and_compare("R7 R10 R12");
  endtask

  task automatic t_smudge_neg();
    defaults();
    c_w = 2; c_h = 3; c_hop = 3; c_sm = 1; c_ln = 1; c_lop = 4'h7;
    c_da = 'h1c0; c_dyi = -12; c_sxi = 4; c_syi = -2; c_skew = 3;
    setup_and_start();
    finish_and_compare("R7 R12 R5");
  endtask

  task automatic t_hog_busy();
    int v;
    defaults();
    c_hog = 1; c_w = 5; c_h = 2; c_lop = 4'h1; c_m2 = 16'h0ff0;
    setup_and_start();
    @(negedge clk);
    chk(hog_req === 1'b1, "R3", "hog request while busy", hog_req, 1);
    rd(28, v); chk(v[7] == 1, "R2", "busy bit readback", v[7], 1);
    wr(24, 'h1234);
    finish_and_compare("R2 R6");
    chk(hog_req === 1'b0, "R3", "hog request after done", hog_req, 0);
    rd(24, v); chk(v == int'(c_m1), "R2", "mask write ignored while busy", v, c_m1);
  endtask

  task automatic t_zero_count();
    int v;
    defaults();
    c_w = 0; c_h = 1; c_hop = 0; c_lop = 4'hf; c_dxi = 0; c_dyi = 0;
    fast = 1;
    setup_and_start();
    while (busy) @(negedge clk);
    fast = 0;
    chk(wr_cnt == 65536, "R4", "words written for zero count", wr_cnt, 65536);
    chk(rd_cnt == 0, "R13", "no reads for ones pattern", rd_cnt, 0);
    chk(mem[ix('h100)] == 16'hffff, "R4", "destination word", mem[ix('h100)], 16'hffff);
    rd(19, v); chk(v == 'h100, "R11", "zero increments keep address", v, 'h100);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy();
    t_skew_fx();
    t_nfsr();
    t_halftone();
    t_smudge_neg();
    t_hog_busy();
    t_zero_count();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule